// File: doc/BRIEF.md
# Baud Rate Tick Generator with Source Select

This block produces the 16x oversampling strobe for a 16550-style serial port. Software programs a 15-bit divisor and a source-select bit through the port's byte-wide register window. The divisor bytes share their offsets with other registers, and they are reachable only while the divisor-access bit of the line control byte is set. The block then divides the chosen source down to a tick that is one clock wide.

Everything runs on a single fast clock. The high-rate source is that clock itself, and every cycle counts. The low-rate source, derived from the fast one, arrives as a clock-enable pulse, and only cycles with that pulse count. Each enabled cycle moves a down-counter one step. When the counter completes a divisor's worth of steps, the block raises the tick and reloads. Software picks the divisor as the source rate divided by sixteen times the wanted baud rate, rounded to the nearest integer.

Top module: `uart_baud_gen`

## Requirements
- R1: Reset clears the line control byte, both divisor bytes and the select bit. While reset is held, and until the third rising edge after `rst_n` goes high, the tick stays low and every read returns 0x00.
- R2: While bit 7 of the line control byte is 1, a write to offset 0 sets divisor bits 7:0. A write to offset 1 sets the source select from data bit 7 and divisor bits 14:8 from data bits 6:0. Reads of offsets 0 and 1 return the last bytes written there, select bit included, on `bus_rdata` in the same cycle as `bus_addr`.
- R3: While bit 7 of the line control byte is 0, writes to offsets 0 and 1 leave the divisor and the select bit unchanged. Reads of offsets 0 and 1 then return 0x00. Offsets 2 and 4 to 7 always read 0x00.
- R4: Offset 3 is the line control byte. It is written and read as all 8 bits whatever the state of the access bit, and its bit 7 is the access bit.
- R5: A divisor of 0 never produces a tick.
- R6: With select 1, every clock cycle is an enabled source cycle. For a divisor D of 1 or more, the tick is high in the cycle after the D-th enabled edge that follows a divisor write, and it repeats every D enabled edges. With D = 1 it is high in every cycle.
- R7: With select 0, only rising edges at which `slow_en` is 1 count as enabled source edges.
- R8: A write to either divisor byte restarts the count from the new value at that edge, whatever count was in progress. The cycle after a divisor write carries no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; also the high-rate baud source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one write per cycle it is high |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| slow_en | input | 1 | Clock-enable pulse of the low-rate source |
| baud_tick | output | 1 | 16x oversampling tick |

## Verification
Register reads are combinational, so read data is due in the same cycle the offset is presented. A write takes effect at the edge it is sampled on and is visible on the next read. The tick is registered, so it rises in the cycle after the enabled edge that completes a divisor period, and the reset synchronizer holds the block idle for two edges after release. The reference model updates at each rising edge, and tick and read data are compared a short delay after that edge, where all of these results have settled.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // Register offsets the block decodes
  localparam logic [ADDR_W-1:0] OFS_DIV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LINE   = 3'd3;

  // Bit positions
  localparam int ACCESS_BIT = 7;  // line control byte: divisor access
  localparam int SELECT_BIT = 7;  // divisor high byte: source select

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } src_sel_e;
endpackage

// File: rtl/uart_baud_rstsync.sv
module uart_baud_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/uart_baud_regs.sv
module uart_baud_regs
  import uart_baud_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int DIV_W = 2*DW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [DW-1:0]    line_q,
  output logic             div_access,
  output logic [DIV_W-1:0] div_val,
  output src_sel_e         clk_sel,
  output logic             div_wr,
  output logic [DIV_W-1:0] div_next
);
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] hi_q, hi_d;
  logic [DW-1:0] line_d;
  logic          hit_lo, hit_hi, hit_line;

  assign div_access = line_q[ACCESS_BIT];

  always_comb begin
    hit_lo   = bus_wr && div_access && (bus_addr == OFS_DIV_LO);
    hit_hi   = bus_wr && div_access && (bus_addr == OFS_DIV_HI);
    hit_line = bus_wr && (bus_addr == OFS_LINE);
    lo_d     = hit_lo   ? bus_wdata : lo_q;
    hi_d     = hit_hi   ? bus_wdata : hi_q;
    line_d   = hit_line ? bus_wdata : line_q;
    div_wr   = hit_lo || hit_hi;
    div_next = {hi_d[DW-2:0], lo_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      line_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      line_q <= line_d;
    end
  end

  assign div_val = {hi_q[DW-2:0], lo_q};
  assign clk_sel = src_sel_e'(hi_q[SELECT_BIT]);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_LINE)                      bus_rdata = line_q;
    else if (div_access && bus_addr == OFS_DIV_LO) bus_rdata = lo_q;
    else if (div_access && bus_addr == OFS_DIV_HI) bus_rdata = hi_q;
  end
endmodule

// File: rtl/uart_baud_srcsel.sv
module uart_baud_srcsel
  import uart_baud_pkg::*;
(
  input  src_sel_e clk_sel,
  input  logic     slow_en,
  output logic     src_en
);
  always_comb begin
    unique case (clk_sel)
      SRC_FAST: src_en = 1'b1;
      default:  src_en = slow_en;
    endcase
  end
endmodule

// File: rtl/uart_baud_divcnt.sv
module uart_baud_divcnt #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             reload,
  input  logic [DIV_W-1:0] reload_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             run;

  always_comb begin
    run    = src_en && (div_val != '0);
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (reload) begin
      cnt_d = reload_val;
    end else if (run) begin
      if (cnt_q <= ONE) begin
        cnt_d  = div_val;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int DIV_W = 2*DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          slow_en,
  output logic          baud_tick
);
  logic             rst_n_sync;
  logic [DW-1:0]    line_q;
  logic             div_access;
  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] div_next;
  logic             div_wr;
  src_sel_e         clk_sel;
  logic             src_en;

  uart_baud_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  uart_baud_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .line_q     (line_q),
    .div_access (div_access),
    .div_val    (div_val),
    .clk_sel    (clk_sel),
    .div_wr     (div_wr),
    .div_next   (div_next)
  );

  uart_baud_srcsel u_src (
    .clk_sel (clk_sel),
    .slow_en (slow_en),
    .src_en  (src_en)
  );

  uart_baud_divcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .src_en     (src_en),
    .div_val    (div_val),
    .reload     (div_wr),
    .reload_val (div_next),
    .tick       (baud_tick)
  );
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk
  import uart_baud_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int DIV_W = 2*DW - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             baud_tick,
  input logic             div_access,
  input logic [DIV_W-1:0] div_val,
  input logic [DW-1:0]    line_q,
  input logic             src_en,
  input logic             div_wr
);
  AST_DIV_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && div_access && bus_addr == OFS_DIV_LO) |=> (div_val[DW-1:0] == $past(bus_wdata))); // R2

  AST_LOCKED_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !div_access && (bus_addr == OFS_DIV_LO || bus_addr == OFS_DIV_HI)) |=> $stable(div_val)); // R3

  AST_LINE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LINE) |=> (line_q == $past(bus_wdata))); // R4

  AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> !baud_tick); // R5

  AST_TICK_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> !baud_tick); // R7

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> !baud_tick); // R8
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .baud_tick  (baud_tick),
  .div_access (div_access),
  .div_val    (div_val),
  .line_q     (line_q),
  .src_en     (src_en),
  .div_wr     (div_wr)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       slow_en;
  logic       baud_tick;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  logic  slow_on = 1'b0;
  int    slow_cnt = 0;

  // reference model state
  int         rel = 0;
  logic [7:0] m_line = 8'h00;
  logic [7:0] m_lo = 8'h00;
  logic [7:0] m_hi = 8'h00;
  int         phase = 0;
  logic       exp_tick = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_baud_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .slow_en   (slow_en),
    .baud_tick (baud_tick)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (a == 3'd3)                 return m_line;
    if (a == 3'd0 && m_line[7])    return m_lo;
    if (a == 3'd1 && m_line[7])    return m_hi;
    return 8'h00;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Low-rate source pulses: one enable every third cycle
  always @(negedge clk) begin
    if (slow_on) begin
      slow_cnt = (slow_cnt + 1) % 3;
      slow_en <= (slow_cnt == 0);
    end else begin
      slow_en <= 1'b0;
    end
  end

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    logic [14:0] dv;
    logic        src;
    if (!rst_n) rel = 0;
    else if (rel < 3) rel++;
    if (rel < 3) begin
      m_line = 8'h00; m_lo = 8'h00; m_hi = 8'h00;
      phase = 0; exp_tick = 1'b0;
    end else begin
      dv  = {m_hi[6:0], m_lo};
      src = m_hi[7] ? 1'b1 : slow_en;
      exp_tick = 1'b0;
      if (bus_wr && m_line[7] && bus_addr == 3'd0) begin
        m_lo = bus_wdata; phase = 0;
      end else if (bus_wr && m_line[7] && bus_addr == 3'd1) begin
        m_hi = bus_wdata; phase = 0;
      end else if (src && dv != 15'd0) begin
        phase++;
        if (phase % int'(dv) == 0) exp_tick = 1'b1;
      end
      if (bus_wr && bus_addr == 3'd3) m_line = bus_wdata;
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    check(cur_req, baud_tick, exp_tick, "tick vs model");
    check(bus_addr == 3'd3 ? "R4" : (m_line[7] ? "R2" : "R3"),
          bus_rdata, exp_rd(bus_addr), "read data vs model");
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp, "register read");
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (baud_tick) c++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00; slow_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", baud_tick, 0, "tick during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset values
    rd_check("R1", 3'd3, 8'h00);
    wr(3'd3, 8'h80);
    rd_check("R1", 3'd0, 8'h00);
    rd_check("R1", 3'd1, 8'h00);

    // R4: line control byte, all bits
    cur_req = "R4";
    wr(3'd3, 8'h9B);
    rd_check("R4", 3'd3, 8'h9B);

    // R6: fast source, divisor 5
    cur_req = "R6";
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h80);
    rd_check("R2", 3'd0, 8'h05);
    rd_check("R2", 3'd1, 8'h80);
    repeat (7) @(negedge clk);
    count_ticks(40, c);
    check("R6", c, 8, "ticks in 40 cycles, divisor 5");

    // R8: reload mid-count
    cur_req = "R8";
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h03);
    repeat (30) @(negedge clk);

    // R6: divisor 1 gives a tick every cycle
    cur_req = "R6";
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    count_ticks(20, c);
    check("R6", c, 20, "ticks in 20 cycles, divisor 1");

    // R7: slow source, divisor 4
    cur_req = "R7";
    slow_on = 1'b1;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h04);
    repeat (30) @(negedge clk);
    count_ticks(48, c);
    check("R7", c, 4, "ticks in 48 cycles, slow source divisor 4");
    wr(3'd0, 8'h02);
    repeat (40) @(negedge clk);

    // R5: divisor 0 is silent, on both sources
    cur_req = "R5";
    wr(3'd0, 8'h00);
    count_ticks(40, c);
    check("R5", c, 0, "ticks with divisor 0, slow source");
    wr(3'd1, 8'h80);
    count_ticks(40, c);
    check("R5", c, 0, "ticks with divisor 0, fast source");

    // R2: select bit and upper divisor bits read back
    cur_req = "R2";
    wr(3'd1, 8'hC2);
    wr(3'd0, 8'h11);
    rd_check("R2", 3'd1, 8'hC2);
    rd_check("R2", 3'd0, 8'h11);

    // R3: divisor locked while the access bit is clear
    cur_req = "R3";
    wr(3'd3, 8'h03);
    wr(3'd0, 8'hAA);
    wr(3'd1, 8'h7F);
    rd_check("R3", 3'd0, 8'h00);
    rd_check("R3", 3'd1, 8'h00);
    rd_check("R3", 3'd2, 8'h00);
    rd_check("R3", 3'd5, 8'h00);
    rd_check("R4", 3'd3, 8'h03);
    wr(3'd3, 8'h83);
    rd_check("R3", 3'd0, 8'h11);
    rd_check("R3", 3'd1, 8'hC2);

    // R8: short divisor, then reload to small value
    cur_req = "R8";
    wr(3'd1, 8'h80);
    wr(3'd0, 8'h07);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h02);
    repeat (20) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule